// File: doc/BRIEF.md
# Retriggerable Dual-Edge One-Shot

This block stretches a trigger event into an output pulse whose length is a programmable number of clock cycles. A counter takes the place of an analog timing network. Two trigger pins are provided. A rising edge on `pos_trig_i` fires the block, but only while `neg_trig_i` is high. A falling edge on `neg_trig_i` fires it whatever the level of `pos_trig_i`. Both pins are synchronized before edges are detected, so they may be driven from another clock domain or straight from a pad.

A trigger sets the output at once, and this does not depend on the timing state. The trigger then starts a timed cycle of two phases. A short settling phase of fixed length comes first, followed by a charge phase whose length comes from `period_i`. When the charge phase ends, `q_o` drops and the block waits idle. A trigger that arrives while the pulse is running restarts the whole timing cycle, so the pulse grows longer. `qn_o` is the complement of `q_o` and has its own register. The active-low reset clears the output, clears the timing state and blocks triggering. The block sees the charge length when the charge phase begins, so `period_i` should be held steady while a pulse runs.

Top module: `retrig_oneshot`

## Requirements
- R1: After reset is released with no trigger, `q_o` is 0 and `qn_o` is 1.
- R2: A 0-to-1 change on `pos_trig_i` while `neg_trig_i` is 1 sets `q_o` at the third rising clock edge after the change. This latency is the same for every value of `period_i`.
- R3: A rising edge on `pos_trig_i` while `neg_trig_i` is 0 is ignored. A rising edge on `neg_trig_i` is never a trigger. In both cases `q_o` stays 0.
- R4: A 1-to-0 change on `neg_trig_i` triggers the block, whether `pos_trig_i` is 0 or 1, with the same three-edge latency as R2.
- R5: For `period_i` = P ≥ 1, `q_o` stays high for exactly P + 2 clock cycles after it is set by a single trigger.
- R6: `period_i` = 0 behaves as 1, which gives a 3-cycle pulse.
- R7: A trigger that takes effect while `q_o` is high restarts the timing cycle. This includes a trigger in the last cycle of the charge phase. `q_o` stays high without a gap and falls P + 2 cycles after the edge at which the last trigger took effect.
- R8: `qn_o` equals the inverse of `q_o` in every cycle.
- R9: Driving `rst_ni` low clears `q_o` at once, without waiting for a clock. Trigger edges that occur while reset is low produce no pulse.
- R10: Releasing reset never produces a pulse, even when `pos_trig_i` is held high across the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all timing is counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pos_trig_i | input | 1 | Trigger on rising edge, qualified by `neg_trig_i` high |
| neg_trig_i | input | 1 | Trigger on falling edge |
| period_i | input | PERIOD_W | Charge-phase length in cycles (0 acts as 1) |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
The tightest overlap is a new trigger landing in the very cycle in which the charge phase expires. In that cycle the expiry would clear `q_o` and the trigger would set it again. The bench times a second `pos_trig_i` edge exactly P + 2 cycles after the first, so that both events fall on one clock edge. The scoreboard then expects one continuous pulse that ends P + 2 cycles after the second trigger. Any one-cycle dip in `q_o`, or an early fall, appears as an extra or misplaced pulse record. A second overlap, an asynchronous reset that arrives in the middle of a pulse, is judged by the fall cycle of that truncated pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DIS  = 2'd1,
        PH_CHG  = 2'd2
    } phase_e;

    // length of the settling phase that precedes the programmed interval
    localparam int unsigned DIS_CYCLES = 2;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/os_trigger.sv
module os_trigger #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pos_s_i,
    input  logic neg_s_i,
    output logic trig_o,
    output logic ready_o
);

    // reset-ready pipe is one stage longer than the input synchronizers,
    // so edges created by reset release are never seen as triggers
    localparam int unsigned RDY_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [RDY_W-1:0] rdy;
        logic             pos_prev;
        logic             neg_prev;
    } trg_t;

    trg_t s_d, s_q;
    logic pos_rise, neg_fall;

    always_comb begin
        s_d          = s_q;
        s_d.rdy      = {s_q.rdy[RDY_W-2:0], 1'b1};
        s_d.pos_prev = pos_s_i;
        s_d.neg_prev = neg_s_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pos_rise = pos_s_i & ~s_q.pos_prev;
    assign neg_fall = ~neg_s_i & s_q.neg_prev;
    assign ready_o  = s_q.rdy[RDY_W-1];
    assign trig_o   = ready_o & ((pos_rise & neg_s_i) | neg_fall);

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int unsigned PERIOD_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                trig_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                q_o,
    output logic                qn_o,
    output phase_e              phase_o,
    output logic [PERIOD_W-1:0] cnt_o
);

    localparam logic [PERIOD_W-1:0] ONE      = PERIOD_W'(1);
    localparam logic [PERIOD_W-1:0] DIS_LAST = PERIOD_W'(DIS_CYCLES - 1);

    typedef struct packed {
        phase_e              ph;
        logic [PERIOD_W-1:0] cnt;
        logic                q;
        logic                qn;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [PERIOD_W-1:0] per_eff;

    always_comb begin
        per_eff = (period_i == '0) ? ONE : period_i;
        s_d     = s_q;
        unique case (s_q.ph)
            PH_DIS: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_CHG;
                    s_d.cnt = per_eff - ONE;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            PH_CHG: begin
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_IDLE;
                    s_d.q  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - ONE;
                end
            end
            default: ;
        endcase
        // a trigger wins over expiry and restarts the whole cycle
        if (trig_i) begin
            s_d.ph  = PH_DIS;
            s_d.cnt = DIS_LAST;
            s_d.q   = 1'b1;
        end
        s_d.qn = ~s_d.q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{ph: PH_IDLE, cnt: '0, q: 1'b0, qn: 1'b1};
        else         s_q <= s_d;
    end

    assign q_o     = s_q.q;
    assign qn_o    = s_q.qn;
    assign phase_o = s_q.ph;
    assign cnt_o   = s_q.cnt;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned PERIOD_W    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                pos_trig_i,
    input  logic                neg_trig_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                q_o,
    output logic                qn_o
);

    logic [1:0]          trig_s;
    logic                trig;
    logic                ready;
    phase_e              phase;
    logic [PERIOD_W-1:0] cnt;

    os_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({neg_trig_i, pos_trig_i}),
        .q_o    (trig_s)
    );

    os_trigger #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trigger (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pos_s_i (trig_s[0]),
        .neg_s_i (trig_s[1]),
        .trig_o  (trig),
        .ready_o (ready)
    );

    os_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trig_i   (trig),
        .period_i (period_i),
        .q_o      (q_o),
        .qn_o     (qn_o),
        .phase_o  (phase),
        .cnt_o    (cnt)
    );

endmodule

// File: rtl/os_checker.sv
module os_checker
    import oneshot_pkg::*;
#(
    parameter int unsigned PERIOD_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                trig_i,
    input logic                ready_i,
    input phase_e              phase_i,
    input logic [PERIOD_W-1:0] cnt_i,
    input logic                q_i,
    input logic                qn_i
);

    // R8
    complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        qn_i == ~q_i);

    // R2
    trig_sets_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |=> q_i);

    // R5
    fall_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q_i) |-> $past(phase_i == PH_CHG && cnt_i == '0 && !trig_i));

    // R3
    rise_needs_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q_i) |-> $past(trig_i));

    // R10
    no_trig_unready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_i |-> !trig_i);

    // R6
    dis_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == PH_DIS) |-> (cnt_i < PERIOD_W'(DIS_CYCLES)));

endmodule

bind retrig_oneshot os_checker #(
    .PERIOD_W (PERIOD_W)
) u_os_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig),
    .ready_i (ready),
    .phase_i (phase),
    .cnt_i   (cnt),
    .q_i     (q_o),
    .qn_i    (qn_o)
);

// File: tb/test_retrig_oneshot.sv
module test_retrig_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 8;

    typedef struct {
        int    rise;
        int    fall;
        string tag;
    } pulse_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pos_t;
    logic          neg_t;
    logic [PW-1:0] period;
    logic          q, qn;

    int     cyc = 0;
    int     n_chk = 0;
    int     n_err = 0;
    int     qn_bad = 0;
    int     rise_c = 0;
    logic   q_prev = 1'b0;
    pulse_t exp_q[$];

    retrig_oneshot #(.PERIOD_W(PW)) i_retrig_oneshot (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pos_trig_i (pos_t),
        .neg_trig_i (neg_t),
        .period_i   (period),
        .q_o        (q),
        .qn_o       (qn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_n(input int k);
        repeat (k) tick();
    endtask

    task automatic push(input int r, input int f, input string tag);
        pulse_t p;
        p.rise = r;
        p.fall = f;
        p.tag  = tag;
        exp_q.push_back(p);
    endtask

    // one-cycle high on pos_trig_i; n is the cycle of the 0-to-1 change
    task automatic rise_pos(output int n);
        pos_t = 1'b1;
        n = cyc;
        tick();
        pos_t = 1'b0;
    endtask

    // monitor: measures each pulse on q and compares with the scoreboard
    always @(negedge clk) begin
        if (qn !== ~q) qn_bad++;
        if (q === 1'b1 && q_prev === 1'b0) rise_c = cyc;
        if (q === 1'b0 && q_prev === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 R10", "unexpected pulse rise", rise_c, -1);
            end else begin
                pulse_t e;
                e = exp_q.pop_front();
                check(rise_c == e.rise, e.tag, "rise cycle", rise_c, e.rise);
                check(cyc == e.fall, e.tag, "fall cycle", cyc, e.fall);
            end
        end
        q_prev = q;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int n, n2, m;
        rst_n  = 1'b0;
        pos_t  = 1'b0;
        neg_t  = 1'b1;
        period = PW'(5);
        wait_n(4);
        rst_n = 1'b1;
        wait_n(6);
        // R1 idle state
        check(q == 1'b0, "R1", "q after reset", int'(q), 0);
        check(qn == 1'b1, "R1", "qn after reset", int'(qn), 1);

        // R2 R5 basic pulse, P = 5
        rise_pos(n);
        push(n + 3, n + 3 + 7, "R2 R5 P=5");
        wait_n(15);

        // R5 minimum period
        period = PW'(1);
        tick();
        rise_pos(n);
        push(n + 3, n + 6, "R2 R5 P=1");
        wait_n(12);

        // R2 latency unchanged with long period
        period = PW'(40);
        tick();
        rise_pos(n);
        push(n + 3, n + 45, "R2 R5 P=40");
        wait_n(50);

        // R6 zero period acts as one
        period = PW'(0);
        tick();
        rise_pos(n);
        push(n + 3, n + 6, "R6");
        wait_n(12);

        // R4 falling neg_trig_i with pos_trig_i low
        period = PW'(3);
        tick();
        neg_t = 1'b0;
        n = cyc;
        push(n + 3, n + 8, "R4 pos low");
        wait_n(12);

        // R3 pos rising while neg low is ignored
        pos_t = 1'b1;
        wait_n(12);
        check(q == 1'b0, "R3", "q after qualified-out pos edge", int'(q), 0);
        neg_t = 1'b1;
        wait_n(8);
        check(q == 1'b0, "R3", "q after neg rising edge", int'(q), 0);

        // R4 falling neg_trig_i with pos_trig_i high
        neg_t = 1'b0;
        n = cyc;
        push(n + 3, n + 8, "R4 pos high");
        wait_n(12);
        pos_t = 1'b0;
        tick();
        neg_t = 1'b1;
        wait_n(6);

        // R7 retrigger in the middle of a pulse
        period = PW'(6);
        tick();
        rise_pos(n);
        wait_n(3);
        rise_pos(n2);
        push(n + 3, n2 + 3 + 8, "R7 mid");
        wait_n(20);

        // R7 retrigger landing on the expiry edge
        rise_pos(n);
        while (cyc < n + 8) tick();
        rise_pos(n2);
        check(n2 == n + 8, "R7", "retrigger cycle placement", n2 - n, 8);
        push(n + 3, n2 + 3 + 8, "R7 expiry");
        wait_n(20);

        // R9 reset in the middle of a pulse
        period = PW'(20);
        tick();
        rise_pos(n);
        wait_n(4);
        m = cyc;
        rst_n = 1'b0;
        push(n + 3, m + 1, "R9");
        #1;
        check(q == 1'b0, "R9", "q right after async reset", int'(q), 0);
        tick();
        pos_t = 1'b1;
        wait_n(2);
        neg_t = 1'b0;
        wait_n(4);
        neg_t = 1'b1;
        wait_n(2);
        check(q == 1'b0, "R9", "q with edges during reset", int'(q), 0);

        // R10 release with pos_trig_i held high
        rst_n = 1'b1;
        wait_n(15);
        check(q == 1'b0, "R10", "q after reset release", int'(q), 0);
        pos_t = 1'b0;
        wait_n(3);

        // recovery after reset
        rise_pos(n);
        push(n + 3, n + 25, "R2 R5 after reset");
        wait_n(30);

        check(exp_q.size() == 0, "R5", "pending expected pulses",
              exp_q.size(), 0);
        check(qn_bad == 0, "R8", "cycles with qn not inverse of q", qn_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule